// File: doc/BRIEF.md
# Host and Controller Byte Mailbox with Shared Interrupt

This block passes single bytes between a host bus and an embedded controller, one latch per direction. The host posts command bytes for the controller and collects reply bytes from it. The controller does the reverse. Each latch has a ready flag that both sides can read as a status bit. Storing a byte raises the flag, and reading the byte from the far side lowers it.

The block also gathers three interrupt sources into one host interrupt line: an 8-bit transfer source, a 16-bit transfer source and a MIDI source. The controller raises a source by writing a control register with its top bit set. The host acknowledges a source as a side effect of reading a particular status address. The line is always the OR of the sources still pending. Two controller-side interrupt inputs are fed by neighbouring logic and cleared by a controller register write.

A host write to the reset port with bit 0 set returns the mailbox to idle and sends a one-cycle reset pulse to the controller. Both sides share one clock. Each side has its own read and write strobes, and each strobe lasts one cycle.

Top module: `hostctl_mailbox`

## Requirements
- R1: After the synchronous reset, both ready flags are 0, all interrupt sources are clear, `h_irq` is 0, `c_int0` and `c_int1` are 0, and `ctl_rst` is 0.
- R2: A host write at offset 4 or 5 stores the command byte and sets the inbound flag. A controller read at address 0 returns that byte and clears the flag at the same clock edge.
- R3: A controller write at address 0 stores the reply byte and sets the outbound flag. A host read at offset 2 or 3 returns that byte and clears the flag.
- R4: A host read at offset 4 returns the inbound flag in bit 7, with all other bits 0. Offset 6 returns the outbound flag in bit 7, with all other bits 0. Offsets 5 and 7 return 0xFF.
- R5: A controller read at address 1 returns the outbound flag in bit 0 and the inbound flag in bit 1, with all other bits 0.
- R6: A controller write with bit 7 set raises a source: address 2 raises the 8-bit source, address 3 the 16-bit source and address 4 the MIDI source. The same writes with bit 7 clear have no effect. `h_irq` equals the OR of the three pending sources.
- R7: The acknowledge reads are: offset 6 clears the 8-bit source, offset 7 clears the 16-bit source, and offset 8 clears the MIDI source. Each leaves the other sources untouched, and `h_irq` follows the OR of what remains.
- R8: When a set and a clear hit the same flag or source in one cycle, the set wins.
- R9: A host write at offset 0 or 1 with bit 0 set clears both ready flags and all sources, so `h_irq` drops. It drives `ctl_rst` high for exactly the next cycle and keeps the stored bytes. With bit 0 clear the same write does nothing.
- R10: A pulse on `c_int0_set` or `c_int1_set` raises `c_int0` or `c_int1`. A controller write at address 5 with bit 6 set clears both. A set in the same cycle beats that clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe; read side effects take place at the clock edge |
| h_addr | input | 4 | Host offset within the block window |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, combinational from address and state |
| h_irq | output | 1 | Shared host interrupt line |
| c_wr | input | 1 | Controller write strobe |
| c_rd | input | 1 | Controller read strobe |
| c_addr | input | 3 | Controller register address |
| c_wdata | input | 8 | Controller write data |
| c_rdata | output | 8 | Controller read data, combinational |
| c_int0_set | input | 1 | Raises controller interrupt 0 (from a neighbour) |
| c_int1_set | input | 1 | Raises controller interrupt 1 (from a neighbour) |
| c_int0 | output | 1 | Controller interrupt input 0 |
| c_int1 | output | 1 | Controller interrupt input 1 |
| ctl_rst | output | 1 | One-cycle controller reset pulse |

## Verification
Every piece of state in this block is visible at a port within one cycle. A ready flag shows in both status views at the first sample after the edge that changed it. A pending source shows on `h_irq`. A wrong flag value therefore shows up as a wrong status bit on the very next read, by either side.

A wrong acknowledge mapping shows in a different way. `h_irq` stays high after the last expected acknowledge, or falls while a source is still pending. For this reason the bench raises every combination of the three sources and checks the line after each acknowledge. A lost reset pulse, or one two cycles wide, shows on `ctl_rst` in the cycle after the reset write.

// File: rtl/mbx_pkg.sv
// Package: shared address map and source indices for the mailbox.
// Assumes host offsets are decoded in even/odd pairs through bits [3:1].
package mbx_pkg;
    // Host offset pair selects (host address bits [3:1])
    localparam logic [2:0] HSEL_FLUSH  = 3'd0;
    localparam logic [2:0] HSEL_REPLY  = 3'd1;
    localparam logic [2:0] HSEL_CMD    = 3'd2;
    localparam logic [2:0] HSEL_RSTAT  = 3'd3;
    localparam logic [2:0] HSEL_MIDACK = 3'd4;

    // Controller register addresses
    localparam logic [2:0] CADR_DATA   = 3'd0;
    localparam logic [2:0] CADR_PORT   = 3'd1;
    localparam logic [2:0] CADR_XFER8  = 3'd2;
    localparam logic [2:0] CADR_XFER16 = 3'd3;
    localparam logic [2:0] CADR_MIDI   = 3'd4;
    localparam logic [2:0] CADR_DACCTL = 3'd5;

    // Interrupt source indices
    localparam int SRC_X8   = 0;
    localparam int SRC_X16  = 1;
    localparam int SRC_MIDI = 2;
    localparam int N_SRC    = 3;
endpackage

// File: rtl/mbx_slot.sv
// Module: one-byte latch with a ready flag for one mailbox direction.
// Assumes put, take and flush are single-cycle strobes. Flush beats put,
// and put beats take. Flush leaves the stored byte alone.
module mbx_slot #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              put,
    input  logic [DATA_W-1:0] put_data,
    input  logic              take,
    output logic [DATA_W-1:0] held,
    output logic              full
);
    // Capture the byte on every put
    always_ff @(posedge clk) begin
        if (!rst_n)   held <= '0;
        else if (put) held <= put_data;
    end

    // Ready flag: flush first, then set, then clear
    always_ff @(posedge clk) begin
        if (!rst_n)      full <= 1'b0;
        else if (flush)  full <= 1'b0;
        else if (put)    full <= 1'b1;
        else if (take)   full <= 1'b0;
    end
endmodule

// File: rtl/mbx_irq_merge.sv
// Module: a set of pending interrupt sources merged onto one line.
// Assumes set, ack and flush are single-cycle. Flush beats set, and set beats ack.
module mbx_irq_merge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic [N-1:0] set,
    input  logic [N-1:0] ack,
    output logic [N-1:0] pending,
    output logic         line
);
    for (genvar g = 0; g < N; g++) begin : g_src
        // One pending flag per source
        always_ff @(posedge clk) begin
            if (!rst_n)      pending[g] <= 1'b0;
            else if (flush)  pending[g] <= 1'b0;
            else if (set[g]) pending[g] <= 1'b1;
            else if (ack[g]) pending[g] <= 1'b0;
        end
    end

    // Shared line is the OR of what is still pending
    always_comb line = |pending;
endmodule

// File: rtl/mbx_host_decode.sv
// Module: host offset decode. Turns strobes into side-effect pulses
// and builds the read data. Assumes read data is sampled while h_rd is
// high; side effects take place at the following clock edge.
module mbx_host_decode
    import mbx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int H_ADDR_W = 4
) (
    input  logic                h_wr,
    input  logic                h_rd,
    input  logic [H_ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0]   h_wdata,
    input  logic                in_full,
    input  logic                out_full,
    input  logic [DATA_W-1:0]   reply_byte,
    output logic                cmd_put,
    output logic                reply_take,
    output logic                flush,
    output logic [N_SRC-1:0]    ack,
    output logic [DATA_W-1:0]   h_rdata
);
    localparam int SEL_W = H_ADDR_W - 1;
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    logic [SEL_W-1:0] sel;
    logic             odd;

    // Split the offset into pair select and odd bit
    always_comb begin
        sel = h_addr[H_ADDR_W-1:1];
        odd = h_addr[0];
    end

    // Strobe decode into side-effect pulses
    always_comb begin
        cmd_put         = h_wr && (sel == SEL_W'(HSEL_CMD));
        flush           = h_wr && (sel == SEL_W'(HSEL_FLUSH)) && h_wdata[0];
        reply_take      = h_rd && (sel == SEL_W'(HSEL_REPLY));
        ack             = '0;
        ack[SRC_X8]     = h_rd && (sel == SEL_W'(HSEL_RSTAT)) && !odd;
        ack[SRC_X16]    = h_rd && (sel == SEL_W'(HSEL_RSTAT)) && odd;
        ack[SRC_MIDI]   = h_rd && (sel == SEL_W'(HSEL_MIDACK));
    end

    // Read data mux
    always_comb begin
        h_rdata = ALL_ONES;
        if (sel == SEL_W'(HSEL_REPLY)) begin
            h_rdata = reply_byte;
        end else if (sel == SEL_W'(HSEL_CMD) && !odd) begin
            h_rdata = '0;
            h_rdata[DATA_W-1] = in_full;
        end else if (sel == SEL_W'(HSEL_RSTAT) && !odd) begin
            h_rdata = '0;
            h_rdata[DATA_W-1] = out_full;
        end
    end
endmodule

// File: rtl/hostctl_mailbox.sv
// Module: top of the host/controller mailbox. Holds two byte slots, the
// host interrupt merge, the controller interrupt inputs and the
// controller reset pulse. Assumes a single clock domain and single-cycle
// strobes on both sides.
module hostctl_mailbox
    import mbx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int H_ADDR_W = 4,
    parameter int C_ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                h_wr,
    input  logic                h_rd,
    input  logic [H_ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0]   h_wdata,
    output logic [DATA_W-1:0]   h_rdata,
    output logic                h_irq,
    input  logic                c_wr,
    input  logic                c_rd,
    input  logic [C_ADDR_W-1:0] c_addr,
    input  logic [DATA_W-1:0]   c_wdata,
    output logic [DATA_W-1:0]   c_rdata,
    input  logic                c_int0_set,
    input  logic                c_int1_set,
    output logic                c_int0,
    output logic                c_int1,
    output logic                ctl_rst
);
    localparam int RAISE_BIT = DATA_W - 1;
    localparam int CCLR_BIT  = DATA_W - 2;

    logic              cmd_put, reply_take, flush;
    logic              reply_put, cmd_take, cint_clr;
    logic              in_full, out_full;
    logic [DATA_W-1:0] cmd_byte, reply_byte;
    logic [N_SRC-1:0]  ack, raise, pending;

    // Host side decode
    mbx_host_decode #(.DATA_W(DATA_W), .H_ADDR_W(H_ADDR_W)) i_hdec (
        .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wdata(h_wdata),
        .in_full(in_full), .out_full(out_full), .reply_byte(reply_byte),
        .cmd_put(cmd_put), .reply_take(reply_take), .flush(flush),
        .ack(ack), .h_rdata(h_rdata)
    );

    // Controller side write and read decode
    always_comb begin
        reply_put       = c_wr && (c_addr == C_ADDR_W'(CADR_DATA));
        cmd_take        = c_rd && (c_addr == C_ADDR_W'(CADR_DATA));
        cint_clr        = c_wr && (c_addr == C_ADDR_W'(CADR_DACCTL)) && c_wdata[CCLR_BIT];
        raise           = '0;
        raise[SRC_X8]   = c_wr && (c_addr == C_ADDR_W'(CADR_XFER8))  && c_wdata[RAISE_BIT];
        raise[SRC_X16]  = c_wr && (c_addr == C_ADDR_W'(CADR_XFER16)) && c_wdata[RAISE_BIT];
        raise[SRC_MIDI] = c_wr && (c_addr == C_ADDR_W'(CADR_MIDI))   && c_wdata[RAISE_BIT];
    end

    // Controller read data mux
    always_comb begin
        c_rdata = '0;
        if (c_addr == C_ADDR_W'(CADR_DATA)) begin
            c_rdata = cmd_byte;
        end else if (c_addr == C_ADDR_W'(CADR_PORT)) begin
            c_rdata[0] = out_full;
            c_rdata[1] = in_full;
        end
    end

    // Host-to-controller command slot
    mbx_slot #(.DATA_W(DATA_W)) i_cmd_slot (
        .clk(clk), .rst_n(rst_n), .flush(flush), .put(cmd_put),
        .put_data(h_wdata), .take(cmd_take), .held(cmd_byte), .full(in_full)
    );

    // Controller-to-host reply slot
    mbx_slot #(.DATA_W(DATA_W)) i_reply_slot (
        .clk(clk), .rst_n(rst_n), .flush(flush), .put(reply_put),
        .put_data(c_wdata), .take(reply_take), .held(reply_byte), .full(out_full)
    );

    // Shared host interrupt
    mbx_irq_merge #(.N(N_SRC)) i_irq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .set(raise), .ack(ack),
        .pending(pending), .line(h_irq)
    );

    // Controller interrupt inputs: a set beats the clear write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_int0 <= 1'b0;
            c_int1 <= 1'b0;
        end else begin
            if (c_int0_set)    c_int0 <= 1'b1;
            else if (cint_clr) c_int0 <= 1'b0;
            if (c_int1_set)    c_int1 <= 1'b1;
            else if (cint_clr) c_int1 <= 1'b0;
        end
    end

    // One-cycle controller reset pulse after a host reset write
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_rst <= 1'b0;
        else        ctl_rst <= flush;
    end
endmodule

// File: rtl/mbx_checks.sv
// Module: checker for hostctl_mailbox. It relates host and controller
// strobes to the flags and lines in the following cycle.
module mbx_checks #(
    parameter int DATA_W   = 8,
    parameter int H_ADDR_W = 4,
    parameter int C_ADDR_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                h_wr,
    input logic                h_rd,
    input logic [H_ADDR_W-1:0] h_addr,
    input logic [DATA_W-1:0]   h_wdata,
    input logic                h_irq,
    input logic                c_wr,
    input logic [C_ADDR_W-1:0] c_addr,
    input logic [DATA_W-1:0]   c_wdata,
    input logic                c_int0_set,
    input logic                c_int0,
    input logic                ctl_rst,
    input logic                in_full,
    input logic                out_full
);
    logic hflush;
    always_comb hflush = h_wr && (h_addr[H_ADDR_W-1:1] == '0) && h_wdata[0];

    AST_CMD_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_addr[H_ADDR_W-1:1] == (H_ADDR_W-1)'(2)) |=> in_full); // R2
    AST_REPLY_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && c_addr == '0 && !hflush) |=> out_full); // R3
    AST_RAISE8_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && c_addr == C_ADDR_W'(2) && c_wdata[DATA_W-1] && !hflush) |=> h_irq); // R6
    AST_IDLE_LINE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_wr && !h_rd && !c_wr) |=> $stable(h_irq)); // R7
    AST_FLUSH_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        hflush |=> (!h_irq && !in_full && !out_full)); // R9
    AST_RST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_rst) |-> $past(hflush)); // R9
    AST_CINT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && c_addr == C_ADDR_W'(5) && c_wdata[DATA_W-2] && !c_int0_set) |=> !c_int0); // R10
endmodule

bind hostctl_mailbox mbx_checks #(
    .DATA_W(DATA_W), .H_ADDR_W(H_ADDR_W), .C_ADDR_W(C_ADDR_W)
) i_mbx_checks (.*);

// File: tb/test_hostctl_mailbox.sv
// Bench: sweeps all byte values in both directions and every combination
// of interrupt sources against each acknowledge. Computes all expected
// values from the requirements.
module test_hostctl_mailbox;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       h_wr = 0, h_rd = 0, c_wr = 0, c_rd = 0;
    logic [3:0] h_addr = '0;
    logic [7:0] h_wdata = '0, c_wdata = '0;
    logic [2:0] c_addr = '0;
    logic       c_int0_set = 0, c_int1_set = 0;
    logic [7:0] h_rdata, c_rdata;
    logic       h_irq, c_int0, c_int1, ctl_rst;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    hostctl_mailbox i_hostctl_mailbox (
        .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq), .c_wr(c_wr),
        .c_rd(c_rd), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
        .c_int0_set(c_int0_set), .c_int1_set(c_int1_set), .c_int0(c_int0),
        .c_int1(c_int1), .ctl_rst(ctl_rst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); h_wr = 1; h_addr = a; h_wdata = d;
        @(negedge clk); h_wr = 0;
    endtask

    task automatic hread(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); h_rd = 1; h_addr = a;
        #1 d = h_rdata;
        @(negedge clk); h_rd = 0;
    endtask

    task automatic cwrite(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); c_wr = 1; c_addr = a; c_wdata = d;
        @(negedge clk); c_wr = 0;
    endtask

    task automatic cread(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); c_rd = 1; c_addr = a;
        #1 d = c_rdata;
        @(negedge clk); c_rd = 0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [7:0] d;
        logic [2:0] rem;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        chk("R1 h_irq", {7'd0, h_irq}, 8'h00);
        chk("R1 c_int", {6'd0, c_int1, c_int0}, 8'h00);
        chk("R1 ctl_rst", {7'd0, ctl_rst}, 8'h00);
        cread(3'd1, d); chk("R1 port status", d, 8'h00);
        hread(4'd4, d); chk("R1 write status", d, 8'h00);

        // R2, R5: all command bytes host to controller
        for (int b = 0; b < 256; b++) begin
            hwrite(4'd4 + 4'(b & 1), 8'(b));
            cread(3'd1, d); chk("R5 in flag set", d, 8'h02);
            hread(4'd4, d); chk("R4 write status full", d, 8'h80);
            cread(3'd0, d); chk("R2 command byte", d, 8'(b));
            cread(3'd1, d); chk("R2 in flag cleared", d, 8'h00);
        end

        // R3, R4, R5: all reply bytes controller to host
        for (int b = 0; b < 256; b++) begin
            cwrite(3'd0, 8'(b));
            cread(3'd1, d); chk("R5 out flag set", d, 8'h01);
            hread(4'd6, d); chk("R4 read status full", d, 8'h80);
            hread(4'd2 + 4'(b & 1), d); chk("R3 reply byte", d, 8'(b));
            hread(4'd6, d); chk("R3 out flag cleared", d, 8'h00);
        end
        hread(4'd5, d); chk("R4 odd write status", d, 8'hFF);
        hread(4'd7, d); chk("R4 odd read status", d, 8'hFF);

        // R6, R7: every source combination, acknowledged in order
        for (int m = 0; m < 8; m++) begin
            cwrite(3'd2, 8'h7F); cwrite(3'd3, 8'h7F); cwrite(3'd4, 8'h7F);
            chk("R6 bit7 clear no raise", {7'd0, h_irq}, 8'h00);
            if (m[0]) cwrite(3'd2, 8'h80);
            if (m[1]) cwrite(3'd3, 8'hFF);
            if (m[2]) cwrite(3'd4, 8'h80);
            chk("R6 line is OR", {7'd0, h_irq}, {7'd0, m != 0});
            rem = 3'(m);
            hread(4'd6, d); rem[0] = 0;
            chk("R7 ack 8-bit", {7'd0, h_irq}, {7'd0, rem != 0});
            hread(4'd7, d); rem[1] = 0;
            chk("R7 ack 16-bit", {7'd0, h_irq}, {7'd0, rem != 0});
            hread(4'd8, d); rem[2] = 0;
            chk("R7 ack MIDI", {7'd0, h_irq}, 8'h00);
        end
        // R7: a 16-bit ack leaves the 8-bit source pending
        cwrite(3'd2, 8'h80);
        hread(4'd7, d); chk("R7 other source kept", {7'd0, h_irq}, 8'h01);
        hread(4'd6, d); chk("R7 last ack drops line", {7'd0, h_irq}, 8'h00);

        // R8: set and acknowledge in the same cycle
        @(negedge clk); c_wr = 1; c_addr = 3'd2; c_wdata = 8'h80; h_rd = 1; h_addr = 4'd6;
        @(negedge clk); c_wr = 0; h_rd = 0;
        chk("R8 raise beats ack", {7'd0, h_irq}, 8'h01);
        hread(4'd6, d);
        cwrite(3'd0, 8'h11);
        @(negedge clk); c_wr = 1; c_addr = 3'd0; c_wdata = 8'h22; h_rd = 1; h_addr = 4'd2;
        #1 chk("R8 host sees old reply", h_rdata, 8'h11);
        @(negedge clk); c_wr = 0; h_rd = 0;
        hread(4'd6, d); chk("R8 put beats take", d, 8'h80);

        // R9: reset port
        hwrite(4'd4, 8'h5A);
        cwrite(3'd3, 8'h80);
        hwrite(4'd0, 8'hFE);
        chk("R9 bit0 clear no effect", {6'd0, h_irq, ctl_rst}, 8'h02);
        cread(3'd1, d); chk("R9 bit0 clear flags kept", d, 8'h03);
        hwrite(4'd1, 8'h01);
        chk("R9 pulse high", {6'd0, h_irq, ctl_rst}, 8'h01);
        @(negedge clk);
        chk("R9 pulse one cycle", {7'd0, ctl_rst}, 8'h00);
        cread(3'd1, d); chk("R9 flags cleared", d, 8'h00);
        cread(3'd0, d); chk("R9 command byte kept", d, 8'h5A);
        hread(4'd2, d); chk("R9 reply byte kept", d, 8'h22);

        // R10: controller interrupt inputs
        @(negedge clk); c_int0_set = 1; c_int1_set = 1;
        @(negedge clk); c_int0_set = 0; c_int1_set = 0;
        chk("R10 set", {6'd0, c_int1, c_int0}, 8'h03);
        cwrite(3'd5, 8'hBF);
        chk("R10 bit6 clear no effect", {6'd0, c_int1, c_int0}, 8'h03);
        cwrite(3'd5, 8'h40);
        chk("R10 clear both", {6'd0, c_int1, c_int0}, 8'h00);
        @(negedge clk); c_int1_set = 1; c_wr = 1; c_addr = 3'd5; c_wdata = 8'h40;
        @(negedge clk); c_int1_set = 0; c_wr = 0;
        chk("R10 set beats clear", {6'd0, c_int1, c_int0}, 8'h02);

        finish_up();
    end
endmodule